// File: doc/BRIEF.md
# Unaligned I/O Access Splitter for a 16-bit Bus

This block sits between a processor's I/O-space access path and a 16-bit peripheral bus. The processor hands it one access of 1 to 4 bytes at any byte offset inside the I/O page. The block turns that access into the shortest legal series of 16-bit bus cycles, which are either word or byte cycles. It never reads a word back in order to merge bytes into it, because reading a device register can change the device's state. For a read, it collects the returned words into a 32-bit result.

The bus side is a request/acknowledge port. A cycle is held steady until the bus acknowledges it. With the acknowledge, the bus reports whether any device answered at that address. If no device answered, the access stops, no further cycles are issued, and a one-cycle machine-check pulse is raised. That pulse carries a cause bit that tells a failed read from a failed write.

While the block works through an access, `busy` stays high and any new request is ignored.

Top module: `io_split_top`

## Requirements
- R1: A 1-byte write at any offset issues exactly one byte-mode write cycle at the access address. Both 8-bit lanes of `busWdata` carry write-data bits 7:0.
- R2: A 2-byte write at an even offset issues one word cycle carrying bits 15:0. At an odd offset it issues two byte cycles instead: first at the address with bits 7:0, then at address+1 with bits 15:8.
- R3: A 3-byte write at an even offset issues a word cycle at the address carrying bits 15:0. It then issues a byte cycle at address+2 carrying bits 23:16.
- R4: A 3-byte write at an odd offset issues a byte cycle at the address carrying bits 7:0. It then issues a word cycle at address+1 carrying bits 23:8.
- R5: A 4-byte write, which is always aligned, issues a word cycle carrying bits 15:0 and then a word cycle at address+2 carrying bits 31:16.
- R6: A read with length plus address bit 0 at most 2 issues one word cycle at the address with bit 0 cleared. The returned word lands in bits 31:16 of the result if address bit 1 is set, and in bits 15:0 otherwise. The other half of the result is zero.
- R7: Any other read issues two word cycles: first at the address with bit 0 cleared, then 2 above it. The result is {second word, first word}.
- R8: Reads use only word cycles. Word cycles always use an even bus address. A cycle's address, mode and data stay unchanged until it is acknowledged.
- R9: An acknowledge with `busNxm` set ends the access at once. One cycle later, `mchkValid` pulses for one cycle, with `mchkWrite` = 1 for a write and 0 for a read. No later cycles are issued and `rspValid` does not pulse.
- R10: `busy` rises in the cycle after a request is accepted and falls with the final acknowledge. Requests made while `busy` is high are ignored. `rspValid` pulses one cycle after the final acknowledge of a successful access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor access request, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | PAGE_W | Byte offset of the access in the I/O page |
| reqLen | input | 3 | Length in bytes, 1 to 4 |
| reqWdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Access in progress |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Assembled read result, valid with rspValid |
| mchkValid | output | 1 | One-cycle machine-check pulse |
| mchkWrite | output | 1 | Machine-check cause: 1 write, 0 read |
| busReq | output | 1 | Bus cycle request |
| busAddr | output | PAGE_W | Bus byte address |
| busByte | output | 1 | 1 = byte cycle, 0 = word cycle |
| busWrite | output | 1 | 1 = write cycle |
| busWdata | output | 16 | Bus write data |
| busAck | input | 1 | Bus cycle acknowledge |
| busRdata | input | 16 | Bus read data, valid with busAck |
| busNxm | input | 1 | No device at the address, valid with busAck |

## Verification
The assertions check the bus-side rules on every cycle. Read cycles are never byte mode, and word cycles never use an odd address. A pending cycle does not change before its acknowledge. A non-existent-device acknowledge always ends the access in a machine check, and a completion pulse and a machine check never occur together. Only the bench's scenarios can show that each length-and-offset combination produces the right number, order, addresses and data lanes of cycles, and that read words are placed correctly in the result. The same holds for aborts that happen midway through a two-cycle access and for requests that are ignored while busy.

// File: rtl/io_split_pkg.sv
package io_split_pkg;
  localparam int BUS_W = 16;
  localparam int CPU_W = 32;
  localparam int LEN_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch a new access
    logic capFirst;   // first read word returned
    logic capSecond;  // second read word returned
    logic selSecond;  // drive the second cycle onto the bus
  } splitStrobe_t;
endpackage

// File: rtl/io_split_datapath.sv
module io_split_datapath
  import io_split_pkg::*;
#(
  parameter int PAGE_W = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  splitStrobe_t           strobe,
  input  logic                   reqWrite,
  input  logic [PAGE_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [CPU_W-1:0]       reqWdata,
  input  logic [BUS_W-1:0]       busRdata,
  input  logic                   busReq,
  output logic                   twoOps,
  output logic                   opWrite,
  output logic [PAGE_W-1:0]      busAddr,
  output logic                   busByte,
  output logic [BUS_W-1:0]       busWdata,
  output logic [CPU_W-1:0]       rspRdata
);
  localparam int LANES = BUS_W / 8;

  logic [PAGE_W-1:0] offQ;
  logic [LEN_W-1:0]  lenQ;
  logic [CPU_W-1:0]  wdQ;
  logic              wrQ;
  logic [CPU_W-1:0]  rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ <= '0;
      lenQ <= '0;
      wdQ  <= '0;
      wrQ  <= 1'b0;
    end else if (strobe.load) begin
      offQ <= reqAddr;
      lenQ <= reqLen;
      wdQ  <= reqWdata;
      wrQ  <= reqWrite;
    end
  end

  // cycle plan for the latched access
  logic              oddOff;
  logic [PAGE_W-1:0] wordBase;
  logic              b0, b1;
  logic [PAGE_W-1:0] a0, a1;
  logic [BUS_W-1:0]  d0, d1;

  assign oddOff   = offQ[0];
  assign wordBase = {offQ[PAGE_W-1:1], 1'b0};

  always_comb begin
    twoOps = 1'b0;
    b0 = 1'b0; b1 = 1'b0;
    a0 = offQ; a1 = offQ + PAGE_W'(1);
    d0 = wdQ[15:0]; d1 = wdQ[31:16];
    if (wrQ) begin
      case (lenQ)
        3'd1: begin
          b0 = 1'b1;
          d0 = {8'h00, wdQ[7:0]};
        end
        3'd2: begin
          if (oddOff) begin
            twoOps = 1'b1;
            b0 = 1'b1; d0 = {8'h00, wdQ[7:0]};
            b1 = 1'b1; d1 = {8'h00, wdQ[15:8]};
          end
        end
        3'd3: begin
          twoOps = 1'b1;
          if (oddOff) begin
            b0 = 1'b1; d0 = {8'h00, wdQ[7:0]};
            d1 = wdQ[23:8];
          end else begin
            a1 = offQ + PAGE_W'(2);
            b1 = 1'b1; d1 = {8'h00, wdQ[23:16]};
          end
        end
        default: begin
          twoOps = 1'b1;
          a1 = offQ + PAGE_W'(2);
        end
      endcase
    end else begin
      twoOps = ({1'b0, lenQ} + {3'b000, oddOff}) > 4'd2;
      a0 = wordBase;
      a1 = wordBase + PAGE_W'(2);
    end
  end

  logic [BUS_W-1:0] opData;
  assign busAddr = strobe.selSecond ? a1 : a0;
  assign busByte = strobe.selSecond ? b1 : b0;
  assign opData  = strobe.selSecond ? d1 : d0;
  assign opWrite = wrQ;

  // byte cycles repeat the byte on every lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign busWdata[g*8 +: 8] = busByte ? opData[7:0] : opData[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobe.load) begin
      rdQ <= '0;
    end else if (strobe.capFirst) begin
      if (twoOps)       rdQ[15:0] <= busRdata;
      else if (offQ[1]) rdQ <= {busRdata, 16'h0000};
      else              rdQ <= {16'h0000, busRdata};
    end else if (strobe.capSecond) begin
      rdQ[31:16] <= busRdata;
    end
  end
  assign rspRdata = rdQ;

  // R8
  read_is_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !opWrite |-> !busByte);
  // R8
  word_even_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busByte |-> !busAddr[0]);
endmodule

// File: rtl/io_split_ctrl.sv
module io_split_ctrl
  import io_split_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         twoOps,
  input  logic         opWrite,
  input  logic         busAck,
  input  logic         busNxm,
  output splitStrobe_t strobe,
  output logic         busy,
  output logic         busReq,
  output logic         rspValid,
  output logic         mchkValid,
  output logic         mchkWrite
);
  splitState_t state, nextState;
  logic accept, lastAck, failAck;

  assign accept  = reqValid && (state == ST_IDLE);
  assign failAck = busAck && busNxm && (state != ST_IDLE);
  assign lastAck = busAck && !busNxm &&
                   ((state == ST_SECOND) || (state == ST_FIRST && !twoOps));

  always_comb begin
    strobe.load      = accept;
    strobe.capFirst  = (state == ST_FIRST)  && busAck && !busNxm;
    strobe.capSecond = (state == ST_SECOND) && busAck && !busNxm;
    strobe.selSecond = (state == ST_SECOND);
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (accept) nextState = ST_FIRST;
      ST_FIRST:  if (busAck) nextState = (busNxm || !twoOps) ? ST_IDLE : ST_SECOND;
      ST_SECOND: if (busAck) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rspValid  <= 1'b0;
      mchkValid <= 1'b0;
      mchkWrite <= 1'b0;
    end else begin
      state     <= nextState;
      rspValid  <= lastAck;
      mchkValid <= failAck;
      if (failAck) mchkWrite <= opWrite;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign busReq = busy;

  // R9
  rsp_mchk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && mchkValid));
  // R9
  nxm_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && busNxm |=> mchkValid && !busReq);
endmodule

// File: rtl/io_split_top.sv
module io_split_top
  import io_split_pkg::*;
#(
  parameter int PAGE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PAGE_W-1:0] reqAddr,
  input  logic [2:0]        reqLen,
  input  logic [31:0]       reqWdata,
  output logic              busy,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              mchkValid,
  output logic              mchkWrite,
  output logic              busReq,
  output logic [PAGE_W-1:0] busAddr,
  output logic              busByte,
  output logic              busWrite,
  output logic [15:0]       busWdata,
  input  logic              busAck,
  input  logic [15:0]       busRdata,
  input  logic              busNxm
);
  splitStrobe_t strobe;
  logic twoOps, opWrite;

  io_split_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .twoOps(twoOps),
    .opWrite(opWrite), .busAck(busAck), .busNxm(busNxm), .strobe(strobe),
    .busy(busy), .busReq(busReq), .rspValid(rspValid),
    .mchkValid(mchkValid), .mchkWrite(mchkWrite)
  );

  io_split_datapath #(.PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .busRdata(busRdata), .busReq(busReq), .twoOps(twoOps),
    .opWrite(opWrite), .busAddr(busAddr), .busByte(busByte),
    .busWdata(busWdata), .rspRdata(rspRdata)
  );

  assign busWrite = opWrite;

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busByte) &&
                          $stable(busWdata) && $stable(busWrite));
endmodule

// File: tb/io_split_top_test.sv
module io_split_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 13;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [PW-1:0] reqAddr = '0;
  logic [2:0] reqLen = 3'd1;
  logic [31:0] reqWdata = '0;
  logic busy, rspValid, mchkValid, mchkWrite, busReq, busByte, busWrite;
  logic [31:0] rspRdata;
  logic [PW-1:0] busAddr;
  logic [15:0] busWdata;
  logic busAck = 1'b0, busNxm = 1'b0;
  logic [15:0] busRdata = '0;

  io_split_top #(.PAGE_W(PW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata), .busy(busy),
    .rspValid(rspValid), .rspRdata(rspRdata), .mchkValid(mchkValid),
    .mchkWrite(mchkWrite), .busReq(busReq), .busAddr(busAddr),
    .busByte(busByte), .busWrite(busWrite), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busNxm(busNxm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, tick = 0;
  bit finished = 0;
  bit ackEn = 1;
  logic [PW-1:0] logA [4];
  logic logB [4], logW [4];
  logic [15:0] logD [4];
  int logN = 0, lastAckTick = 0, doneTick = 0;
  bit sawRsp = 0, sawMchk = 0;
  logic [31:0] gotData = '0;
  logic gotMchkW = 1'b0;

  function automatic logic [15:0] devWord(logic [PW-1:0] a);
    return 16'(({3'b000, a} * 16'd37) ^ 16'hC3A5);
  endfunction

  function automatic logic isAbsent(logic [PW-1:0] a);
    return a[PW-1:PW-4] == 4'hF;
  endfunction

  // bus responder and output monitor, all on the falling edge
  always @(negedge clk) begin
    tick++;
    if (busAck) begin
      busAck = 1'b0;
      busNxm = 1'b0;
    end else if (busReq && ackEn && ($urandom_range(0, 2) != 0)) begin
      if (logN < 4) begin
        logA[logN] = busAddr; logB[logN] = busByte;
        logW[logN] = busWrite; logD[logN] = busWdata;
      end
      logN++;
      busAck = 1'b1;
      busNxm = isAbsent(busAddr);
      busRdata = devWord(busAddr);
      lastAckTick = tick;
    end
    if (rspValid) begin sawRsp = 1; gotData = rspRdata; doneTick = tick; end
    if (mchkValid) begin sawMchk = 1; gotMchkW = mchkWrite; doneTick = tick; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runAccess(input logic wr, input logic [PW-1:0] a, input int len,
                           input logic [31:0] wd, input bit stall);
    int eN = 1;
    logic [PW-1:0] eA [2];
    logic eB [2];
    logic [15:0] eD [2];
    logic [31:0] eR = '0;
    string tag;
    int expCount, waitCnt, oldN;
    bit expMchk;
    logic [PW-1:0] wb;
    wb = {a[PW-1:1], 1'b0};
    eA[0] = a; eA[1] = a + PW'(1); eB[0] = 0; eB[1] = 0;
    eD[0] = wd[15:0]; eD[1] = wd[31:16];
    if (wr) begin
      case (len)
        1: begin tag = "R1"; eB[0] = 1; eD[0] = {wd[7:0], wd[7:0]}; end
        2: begin
          tag = "R2";
          if (a[0]) begin
            eN = 2; eB[0] = 1; eB[1] = 1;
            eD[0] = {wd[7:0], wd[7:0]}; eD[1] = {wd[15:8], wd[15:8]};
          end
        end
        3: begin
          eN = 2;
          if (a[0]) begin
            tag = "R4"; eB[0] = 1; eD[0] = {wd[7:0], wd[7:0]}; eD[1] = wd[23:8];
          end else begin
            tag = "R3"; eA[1] = a + PW'(2); eB[1] = 1; eD[1] = {wd[23:16], wd[23:16]};
          end
        end
        default: begin tag = "R5"; eN = 2; eA[1] = a + PW'(2); end
      endcase
    end else begin
      eA[0] = wb; eA[1] = wb + PW'(2);
      if (len + int'(a[0]) <= 2) begin
        tag = "R6";
        eR = a[1] ? {devWord(wb), 16'h0} : {16'h0, devWord(wb)};
      end else begin
        tag = "R7"; eN = 2;
        eR = {devWord(eA[1]), devWord(wb)};
      end
    end
    expCount = eN; expMchk = 0;
    if (isAbsent(eA[0])) begin expCount = 1; expMchk = 1; end
    else if (eN == 2 && isAbsent(eA[1])) begin expMchk = 1; end

    @(negedge clk);
    logN = 0; sawRsp = 0; sawMchk = 0;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqLen = 3'(len); reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    check(busy == 1'b1, "R10", "busy after accept", 32'(busy), 1);
    if (stall) begin
      ackEn = 0;
      reqValid = 1; reqWrite = ~wr; reqAddr = a ^ PW'(4); reqLen = 3'd1; reqWdata = ~wd;
      @(negedge clk);
      @(negedge clk);
      reqValid = 0;
      ackEn = 1;
    end
    waitCnt = 0;
    while (!sawRsp && !sawMchk && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    check(logN == expCount, tag, "cycle count", 32'(logN), 32'(expCount));
    for (int i = 0; i < expCount && i < logN; i++) begin
      check(logA[i] == eA[i], tag, "cycle address", 32'(logA[i]), 32'(eA[i]));
      check(logB[i] == eB[i], tag, "cycle byte mode", 32'(logB[i]), 32'(eB[i]));
      check(logW[i] == wr, "R8", "cycle direction", 32'(logW[i]), 32'(wr));
      if (wr) check(logD[i] == eD[i], tag, "cycle write data", 32'(logD[i]), 32'(eD[i]));
    end
    if (expMchk) begin
      check(sawMchk && !sawRsp, "R9", "machine check raised", {30'b0, sawMchk, sawRsp}, 32'h2);
      check(gotMchkW == wr, "R9", "machine check cause", 32'(gotMchkW), 32'(wr));
      check(doneTick == lastAckTick + 1, "R9", "machine check timing",
            32'(doneTick), 32'(lastAckTick + 1));
    end else begin
      check(sawRsp && !sawMchk, "R10", "completion pulse", {30'b0, sawMchk, sawRsp}, 32'h1);
      check(doneTick == lastAckTick + 1, "R10", "completion timing",
            32'(doneTick), 32'(lastAckTick + 1));
      if (!wr) check(gotData == eR, tag, "read result", gotData, eR);
    end
    check(busy == 1'b0, "R10", "idle after finish", 32'(busy), 0);
    if (stall) begin
      oldN = logN;
      repeat (3) @(negedge clk);
      check(busReq == 1'b0 && logN == oldN, "R10", "request while busy ignored",
            32'(logN), 32'(oldN));
    end
  endtask

  function automatic logic [PW-1:0] pickAddr(int len);
    logic [PW-1:0] a;
    a = PW'($urandom);
    if ($urandom_range(0, 5) != 0) a[PW-1:PW-4] = 4'($urandom_range(0, 14));
    case (len)
      4: a[1:0] = 2'b00;
      3: a[1] = 1'b0;
      2: if (a[1:0] == 2'b11) a[1:0] = 2'b10;
      default: ;
    endcase
    return a;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", tick);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !busReq && !rspValid && !mchkValid, "R10", "reset state",
          {28'b0, busy, busReq, rspValid, mchkValid}, 0);
    rstN = 1;
    @(negedge clk);
    // directed corners
    runAccess(1, 13'h0101, 1, 32'h0000_00A7, 0);
    runAccess(1, 13'h0100, 2, 32'h0000_BEEF, 0);
    runAccess(1, 13'h0103, 2, 32'h0000_1234, 0);
    runAccess(1, 13'h0200, 3, 32'h00C0_FFEE, 0);
    runAccess(1, 13'h0201, 3, 32'h0055_AA11, 0);
    runAccess(1, 13'h0300, 4, 32'hDEAD_BEEF, 1);
    runAccess(0, 13'h0302, 2, 32'h0, 0);
    runAccess(0, 13'h0303, 1, 32'h0, 0);
    runAccess(0, 13'h0301, 2, 32'h0, 1);
    runAccess(0, 13'h0300, 4, 32'h0, 0);
    runAccess(1, 13'h1E10, 2, 32'h0000_7777, 0);
    runAccess(0, 13'h1DFD, 3, 32'h0, 0);
    runAccess(1, 13'h1DFF, 2, 32'h0000_4321, 0);
    // random mix
    for (int n = 0; n < 300; n++) begin
      int len;
      logic [PW-1:0] a;
      len = $urandom_range(1, 4);
      a = pickAddr(len);
      if (len == 3 || len == 2) begin
        if (a[1:0] == 2'b11) a[1:0] = 2'b01;
      end
      runAccess(1'($urandom), a, len, $urandom, (n % 37) == 5);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule